// File: doc/BRIEF.md
# Indexed USB Endpoint Control Bank

This block holds one 8-bit control word for each endpoint of a four-endpoint USB device. Software sees all of these words through a single control address. A 2-bit index register, at a second address, decides which endpoint's word that address reaches. Reads return data combinationally. Writes land on the clock edge of the write strobe.

Alongside the storage, the block turns each token reported by the serial engine into a response decision. The token carries a type, an endpoint number and the setup-received flag. The decision is one of: no response, ACK-eligible, STALL, or no handshake (isochronous). The decision comes with isochronous and dual-buffer mode flags for the transfer engines, and is registered one clock after the token strobe.

Control word bits, MSB to LSB:
- bit 7: receive stall
- bit 6: transmit stall
- bit 5: receive dual-buffer
- bit 4: transmit dual-buffer
- bit 3: receive isochronous
- bit 2: receive enable
- bit 1: transmit enable's isochronous partner (transmit isochronous)
- bit 0: transmit enable

Token type codes:
- 0: OUT
- 1: IN
- 2: SETUP
- 3: reserved

Response codes:
- 0: none
- 1: ACK-eligible
- 2: STALL
- 3: no handshake

Top module: `usb_ep_ctrl_bank`

## Requirements
- R1: A write to address E1h stores the 8-bit word into the endpoint picked by the index register. A read of E1h returns that endpoint's word in the same cycle. Words of other endpoints stay unchanged.
- R2: The index register sits at address E2h and holds 2 bits. It reads back zero-extended. Any other address reads as 00h.
- R3: After rst_ni, or on the clock after usb_reset_i, endpoint 0's word is 05h (both enables set), endpoints 1 to 3 hold 00h, and the index is 0.
- R4: An OUT or SETUP token to an endpoint with receive enable (bit 2) clear gives response 0. An IN token with transmit enable (bit 0) clear gives response 0.
- R5: An enabled, non-isochronous OUT with receive stall (bit 7) set and the setup flag clear gives response 2. An enabled, non-isochronous IN with transmit stall (bit 6) set gives response 2.
- R6: A SETUP token to an enabled endpoint always gives response 1. An enabled non-isochronous OUT with the setup flag set gives response 1 even when receive stall is set.
- R7: Receive isochronous (bit 3) acts only on endpoint 3 OUT, and transmit isochronous (bit 1) acts only on endpoint 2 IN. When it acts on an enabled endpoint, the response is 3 and dec_iso_o is 1, whatever the stall bits say.
- R8: dec_dbuf_o follows receive dual-buffer (bit 5) only for an enabled endpoint 3 OUT, and transmit dual-buffer (bit 4) only for an enabled endpoint 2 IN. In every other case it is 0.
- R9: dec_valid_o is high exactly one clock after tok_valid_i. dec_ep_o and dec_in_o echo that token's endpoint and IN-ness.
- R10: A control write in the same cycle as a token does not affect that token's decision. The next token sees the new word.
- R11: A reserved token type (3) gives response 0 with both mode flags 0. Any response 0 has both mode flags 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| usb_reset_i | input | 1 | Synchronous USB bus reset |
| cpu_addr_i | input | 8 | Register address |
| cpu_we_i | input | 1 | Write strobe |
| cpu_wdata_i | input | 8 | Write data |
| cpu_rdata_o | output | 8 | Combinational read data |
| tok_valid_i | input | 1 | Token strobe |
| tok_type_i | input | 2 | Token type code |
| tok_ep_i | input | 2 | Token endpoint number |
| setup_flag_i | input | 1 | Setup-received flag |
| dec_valid_o | output | 1 | Decision strobe |
| dec_resp_o | output | 2 | Response code |
| dec_ep_o | output | 2 | Endpoint of the decision |
| dec_in_o | output | 1 | Decision is for an IN token |
| dec_iso_o | output | 1 | Isochronous transfer |
| dec_dbuf_o | output | 1 | Dual-buffer transfer |

## Verification
The assertions check the following on every cycle:
- the one-clock token-to-decision timing;
- that SETUP never draws STALL;
- that isochronous decisions occur only on the two special endpoint/direction pairs and always carry the no-handshake code;
- that a silent decision carries no mode flags;
- the bus-reset values;
- that a write leaves the other endpoints' words alone.

Only the bench's scenarios can show the rest:
- the full mapping from all 256 control words, four endpoints, four token types and both setup-flag values to the decision;
- read-back through the banked address;
- write-versus-token ordering in the same cycle.

// File: rtl/usb_ep_pkg.sv
package usb_ep_pkg;
  typedef enum logic [1:0] {
    TOK_OUT   = 2'd0,
    TOK_IN    = 2'd1,
    TOK_SETUP = 2'd2,
    TOK_RSVD  = 2'd3
  } tok_e;

  typedef enum logic [1:0] {
    RSP_NONE  = 2'd0,
    RSP_ACK   = 2'd1,
    RSP_STALL = 2'd2,
    RSP_NOHS  = 2'd3
  } rsp_e;

  typedef struct packed {
    logic rx_stall;
    logic tx_stall;
    logic rx_dbuf;
    logic tx_dbuf;
    logic rx_iso;
    logic rx_en;
    logic tx_iso;
    logic tx_en;
  } ep_ctrl_t;

  localparam int unsigned CTRL_W = $bits(ep_ctrl_t);
  localparam ep_ctrl_t EP0_RST = ep_ctrl_t'(8'h05);
endpackage

// File: rtl/ep_index_reg.sv
module ep_index_reg #(
  parameter int unsigned EP_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            bus_rst_i,
  input  logic            wr_i,
  input  logic [EP_W-1:0] wdata_i,
  output logic [EP_W-1:0] idx_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        idx_o <= '0;
    else if (bus_rst_i) idx_o <= '0;
    else if (wr_i)      idx_o <= wdata_i;
  end

  p_idx_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !bus_rst_i) |=> idx_o == $past(wdata_i));
  p_idx_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rst_i |=> idx_o == '0);
endmodule

// File: rtl/ep_ctrl_regfile.sv
module ep_ctrl_regfile
  import usb_ep_pkg::*;
#(
  parameter int unsigned NUM_EP = 4,
  localparam int unsigned EP_W = $clog2(NUM_EP)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     bus_rst_i,
  input  logic                     wr_i,
  input  logic [EP_W-1:0]          wr_idx_i,
  input  ep_ctrl_t                 wdata_i,
  output ep_ctrl_t [NUM_EP-1:0]    words_o
);
  for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
    localparam ep_ctrl_t RST_V = (g == 0) ? EP0_RST : ep_ctrl_t'('0);
    localparam logic [EP_W-1:0] MY_IDX = EP_W'(g);
    logic sel;
    assign sel = wr_i && (wr_idx_i == MY_IDX);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        words_o[g] <= RST_V;
      else if (bus_rst_i) words_o[g] <= RST_V;
      else if (sel)       words_o[g] <= wdata_i;
    end

    p_bus_rst_val_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bus_rst_i |=> words_o[g] == RST_V);
    p_write_local_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!bus_rst_i && !(wr_i && wr_idx_i == MY_IDX)) |=> words_o[g] == $past(words_o[g]));
  end
endmodule

// File: rtl/ep_resp_decider.sv
module ep_resp_decider
  import usb_ep_pkg::*;
#(
  parameter int unsigned NUM_EP        = 4,
  parameter int unsigned RX_SPECIAL_EP = 3,
  parameter int unsigned TX_SPECIAL_EP = 2,
  localparam int unsigned EP_W = $clog2(NUM_EP)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  tok_valid_i,
  input  logic [1:0]            tok_type_i,
  input  logic [EP_W-1:0]       tok_ep_i,
  input  logic                  setup_flag_i,
  input  ep_ctrl_t [NUM_EP-1:0] words_i,
  output logic                  dec_valid_o,
  output logic [1:0]            dec_resp_o,
  output logic [EP_W-1:0]       dec_ep_o,
  output logic                  dec_in_o,
  output logic                  dec_iso_o,
  output logic                  dec_dbuf_o
);
  localparam logic [EP_W-1:0] RX_EP = EP_W'(RX_SPECIAL_EP);
  localparam logic [EP_W-1:0] TX_EP = EP_W'(TX_SPECIAL_EP);

  ep_ctrl_t w;
  logic     rx_sp, tx_sp;
  rsp_e     rsp_n;
  logic     iso_n, dbuf_n;

  assign w     = words_i[tok_ep_i];
  assign rx_sp = (tok_ep_i == RX_EP);
  assign tx_sp = (tok_ep_i == TX_EP);

  always_comb begin
    rsp_n  = RSP_NONE;
    iso_n  = 1'b0;
    dbuf_n = 1'b0;
    unique case (tok_e'(tok_type_i))
      TOK_OUT: if (w.rx_en) begin
        iso_n  = w.rx_iso & rx_sp;
        dbuf_n = w.rx_dbuf & rx_sp;
        if (iso_n)                          rsp_n = RSP_NOHS;
        else if (w.rx_stall && !setup_flag_i) rsp_n = RSP_STALL;
        else                                rsp_n = RSP_ACK;
      end
      TOK_IN: if (w.tx_en) begin
        iso_n  = w.tx_iso & tx_sp;
        dbuf_n = w.tx_dbuf & tx_sp;
        if (iso_n)           rsp_n = RSP_NOHS;
        else if (w.tx_stall) rsp_n = RSP_STALL;
        else                 rsp_n = RSP_ACK;
      end
      TOK_SETUP: if (w.rx_en) rsp_n = RSP_ACK;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_valid_o <= 1'b0;
      dec_resp_o  <= RSP_NONE;
      dec_ep_o    <= '0;
      dec_in_o    <= 1'b0;
      dec_iso_o   <= 1'b0;
      dec_dbuf_o  <= 1'b0;
    end else begin
      dec_valid_o <= tok_valid_i;
      if (tok_valid_i) begin
        dec_resp_o <= rsp_n;
        dec_ep_o   <= tok_ep_i;
        dec_in_o   <= (tok_type_i == TOK_IN);
        dec_iso_o  <= iso_n;
        dec_dbuf_o <= dbuf_n;
      end
    end
  end

  p_dec_lat_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tok_valid_i |=> dec_valid_o);
  p_dec_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tok_valid_i |=> !dec_valid_o);
  p_setup_no_stall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tok_valid_i && tok_type_i == TOK_SETUP) |=> dec_resp_o != RSP_STALL);
  p_iso_place_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_o && dec_iso_o) |-> (dec_in_o ? dec_ep_o == TX_EP : dec_ep_o == RX_EP));
  p_iso_nohs_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_o && dec_iso_o) |-> dec_resp_o == RSP_NOHS);
  p_quiet_flags_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_o && dec_resp_o == RSP_NONE) |-> !dec_iso_o && !dec_dbuf_o);
endmodule

// File: rtl/usb_ep_ctrl_bank.sv
module usb_ep_ctrl_bank
  import usb_ep_pkg::*;
#(
  parameter int unsigned NUM_EP        = 4,
  parameter int unsigned ADDR_W        = 8,
  parameter logic [7:0]  CTRL_ADDR     = 8'hE1,
  parameter logic [7:0]  IDX_ADDR      = 8'hE2,
  parameter int unsigned RX_SPECIAL_EP = 3,
  parameter int unsigned TX_SPECIAL_EP = 2,
  localparam int unsigned EP_W = $clog2(NUM_EP)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              usb_reset_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic              cpu_we_i,
  input  logic [CTRL_W-1:0] cpu_wdata_i,
  output logic [CTRL_W-1:0] cpu_rdata_o,
  input  logic              tok_valid_i,
  input  logic [1:0]        tok_type_i,
  input  logic [EP_W-1:0]   tok_ep_i,
  input  logic              setup_flag_i,
  output logic              dec_valid_o,
  output logic [1:0]        dec_resp_o,
  output logic [EP_W-1:0]   dec_ep_o,
  output logic              dec_in_o,
  output logic              dec_iso_o,
  output logic              dec_dbuf_o
);
  logic                  hit_ctrl, hit_idx;
  logic [EP_W-1:0]       idx;
  ep_ctrl_t [NUM_EP-1:0] words;
  logic                  unused_wdata_hi;

  assign hit_ctrl        = (cpu_addr_i == ADDR_W'(CTRL_ADDR));
  assign hit_idx         = (cpu_addr_i == ADDR_W'(IDX_ADDR));
  assign unused_wdata_hi = ^cpu_wdata_i[CTRL_W-1:EP_W];

  ep_index_reg #(.EP_W(EP_W)) u_idx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bus_rst_i (usb_reset_i),
    .wr_i      (cpu_we_i && hit_idx),
    .wdata_i   (cpu_wdata_i[EP_W-1:0]),
    .idx_o     (idx)
  );

  ep_ctrl_regfile #(.NUM_EP(NUM_EP)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bus_rst_i (usb_reset_i),
    .wr_i      (cpu_we_i && hit_ctrl),
    .wr_idx_i  (idx),
    .wdata_i   (ep_ctrl_t'(cpu_wdata_i)),
    .words_o   (words)
  );

  ep_resp_decider #(
    .NUM_EP        (NUM_EP),
    .RX_SPECIAL_EP (RX_SPECIAL_EP),
    .TX_SPECIAL_EP (TX_SPECIAL_EP)
  ) u_dec (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tok_valid_i  (tok_valid_i),
    .tok_type_i   (tok_type_i),
    .tok_ep_i     (tok_ep_i),
    .setup_flag_i (setup_flag_i),
    .words_i      (words),
    .dec_valid_o  (dec_valid_o),
    .dec_resp_o   (dec_resp_o),
    .dec_ep_o     (dec_ep_o),
    .dec_in_o     (dec_in_o),
    .dec_iso_o    (dec_iso_o),
    .dec_dbuf_o   (dec_dbuf_o)
  );

  always_comb begin
    if (hit_ctrl)     cpu_rdata_o = words[idx];
    else if (hit_idx) cpu_rdata_o = CTRL_W'(idx);
    else              cpu_rdata_o = '0;
  end

  p_rd_ctrl_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_we_i && hit_ctrl && !usb_reset_i) |=> (hit_ctrl && $stable(idx)) -> cpu_rdata_o == $past(cpu_wdata_i));
endmodule

// File: tb/usb_ep_ctrl_bank_bench.sv
module usb_ep_ctrl_bank_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       usb_rst = 1'b0;
  logic [7:0] addr = 8'h00;
  logic       we = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       tv = 1'b0;
  logic [1:0] tt = 2'd0;
  logic [1:0] tep = 2'd0;
  logic       sf = 1'b0;
  logic       dv, din, diso, ddb;
  logic [1:0] dresp, dep;
  int         errors = 0;
  int         checks = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  usb_ep_ctrl_bank u_usb_ep_ctrl_bank (
    .clk_i(clk), .rst_ni(rst_n), .usb_reset_i(usb_rst),
    .cpu_addr_i(addr), .cpu_we_i(we), .cpu_wdata_i(wdata), .cpu_rdata_o(rdata),
    .tok_valid_i(tv), .tok_type_i(tt), .tok_ep_i(tep), .setup_flag_i(sf),
    .dec_valid_o(dv), .dec_resp_o(dresp), .dec_ep_o(dep), .dec_in_o(din),
    .dec_iso_o(diso), .dec_dbuf_o(ddb)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cpu_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic cpu_rd(input logic [7:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic token(input int ep, input int t, input logic f);
    @(negedge clk);
    tv = 1'b1; tep = 2'(ep); tt = 2'(t); sf = f;
    @(negedge clk);
    tv = 1'b0;
  endtask

  // expected {resp[1:0], iso, dbuf} from the requirements
  function automatic logic [3:0] model(input int ep, input logic [7:0] w, input int t, input logic f);
    logic [1:0] r; logic iso, db;
    r = 2'd0; iso = 1'b0; db = 1'b0;
    if (t == 0 && w[2]) begin
      iso = w[3] && ep == 3; db = w[5] && ep == 3;
      r = iso ? 2'd3 : (w[7] && !f) ? 2'd2 : 2'd1;
    end else if (t == 1 && w[0]) begin
      iso = w[1] && ep == 2; db = w[4] && ep == 2;
      r = iso ? 2'd3 : w[6] ? 2'd2 : 2'd1;
    end else if (t == 2 && w[2]) begin
      r = 2'd1;
    end
    return {r, iso, db};
  endfunction

  function automatic string tag_of(input int ep, input logic [7:0] w, input int t, input logic f);
    if (t == 3) return "R11";
    if (t == 2) return w[2] ? "R6" : "R4";
    if (t == 0) begin
      if (!w[2]) return "R4";
      if (w[3] && ep == 3) return "R7";
      if (w[7]) return f ? "R6" : "R5";
      return "R1";
    end
    if (!w[0]) return "R4";
    if (w[1] && ep == 2) return "R7";
    if (w[6]) return "R5";
    return "R1";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [3:0] e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R3 reset state
    cpu_rd(8'hE2, d); check(d == 8'h00, "R3 index", d, 0);
    for (int ep = 0; ep < 4; ep++) begin
      cpu_wr(8'hE2, 8'(ep));
      cpu_rd(8'hE1, d);
      check(d == (ep == 0 ? 8'h05 : 8'h00), "R3 word", d, ep == 0 ? 5 : 0);
    end
    check(dv == 1'b0, "R9 idle", dv, 0);
    // R2 unmapped address and index readback
    cpu_rd(8'h40, d); check(d == 8'h00, "R2 other addr", d, 0);
    cpu_wr(8'hE2, 8'hFE); cpu_rd(8'hE2, d); check(d == 8'h02, "R2 index width", d, 2);

    // exhaustive sweep: endpoint x word x token type x setup flag
    for (int ep = 0; ep < 4; ep++) begin
      cpu_wr(8'hE2, 8'(ep));
      for (int w = 0; w < 256; w++) begin
        cpu_wr(8'hE1, 8'(w));
        cpu_rd(8'hE1, d); check(d == 8'(w), "R1 readback", d, w);
        for (int t = 0; t < 4; t++) begin
          for (int f = 0; f < 2; f++) begin
            token(ep, t, 1'(f));
            e = model(ep, 8'(w), t, 1'(f));
            check(dv && dresp == e[3:2] && diso == e[1],
                  tag_of(ep, 8'(w), t, 1'(f)), {dv, dresp, diso}, {1'b1, e[3:1]});
            check(ddb == e[0], (e[1] || t == 3) ? "R11 dbuf" : "R8", ddb, e[0]);
            check(dep == 2'(ep) && din == (t == 1), "R9 echo", {dep, din}, {ep[1:0], t == 1});
          end
        end
      end
    end
    @(negedge clk);
    check(dv == 1'b0, "R9 single pulse", dv, 0);

    // R1 bank isolation: all words hold FFh now
    cpu_wr(8'hE2, 8'd1); cpu_wr(8'hE1, 8'h12);
    cpu_wr(8'hE2, 8'd0); cpu_rd(8'hE1, d); check(d == 8'hFF, "R1 isolation ep0", d, 8'hFF);
    cpu_wr(8'hE2, 8'd2); cpu_rd(8'hE1, d); check(d == 8'hFF, "R1 isolation ep2", d, 8'hFF);
    cpu_wr(8'hE2, 8'd1); cpu_rd(8'hE1, d); check(d == 8'h12, "R1 isolation ep1", d, 8'h12);

    // R10 write in the same cycle as a token
    cpu_wr(8'hE1, 8'h04);
    @(negedge clk);
    addr = 8'hE1; wdata = 8'h84; we = 1'b1;
    tv = 1'b1; tep = 2'd1; tt = 2'd0; sf = 1'b0;
    @(negedge clk);
    we = 1'b0; tv = 1'b0;
    check(dv && dresp == 2'd1, "R10 old word", dresp, 1);
    token(1, 0, 1'b0);
    check(dv && dresp == 2'd2, "R10 new word", dresp, 2);

    // R3 USB bus reset
    @(negedge clk); usb_rst = 1'b1;
    @(negedge clk); usb_rst = 1'b0;
    cpu_rd(8'hE2, d); check(d == 8'h00, "R3 bus reset index", d, 0);
    for (int ep = 0; ep < 4; ep++) begin
      cpu_wr(8'hE2, 8'(ep));
      cpu_rd(8'hE1, d);
      check(d == (ep == 0 ? 8'h05 : 8'h00), "R3 bus reset word", d, ep == 0 ? 5 : 0);
    end
    token(0, 1, 1'b0);
    check(dresp == 2'd1, "R3 ep0 enabled IN", dresp, 1);
    token(1, 1, 1'b0);
    check(dresp == 2'd0, "R4 ep1 disabled IN", dresp, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule